// File: doc/BRIEF.md
# HDLC Transmit Framer with Programmable Flag Fill

This block turns host-supplied frames into a serial HDLC bit stream for a modulator. The host writes frame bytes into a pair of alternating byte buffers. While one buffer drains onto the line, the other can be filled. Each frame goes out as its data, then a 16-bit frame check sequence, then flag octets (0x7E). Zero-bit insertion keeps the flag pattern from appearing inside a frame.

Three flag counts are set from outside the block: one for the leading run before the first frame, one for the gap between frames, and one for the tail after the last frame. If the host is late with the next frame, the framer keeps sending flags until a frame is ready. A stop command ends the session with the tail run, never with the gap run. Frames that are already queued when the stop arrives are still sent first.

The modulator paces the line with a single-cycle bit request. Each request yields exactly one line bit, which is presented with a valid strobe.

Top module: `hdlc_flag_framer`

## Requirements
- R1: After reset, and until a start command, `tx_vld` and `buf_irq` stay low and no bit is sent.
- R2: After a start command, `lead_flags`+1 flag octets (0x7E, sent LSB first: 0,1,1,1,1,1,1,0) go out before the first frame.
- R3: Between two frames that are both ready in time, exactly `gap_flags`+1 flag octets are sent.
- R4: When a frame's FCS ends while a stop is pending and no further frame is ready, `tail_flags`+1 flag octets follow and the line then goes quiet. Frames already queued when the stop arrived are sent first, each separated by the gap run.
- R5: A stop that arrives while only flags are being sent takes effect when the current flag run ends. It is followed by `tail_flags`+1 flags, and then the line goes quiet.
- R6: When a flag run ends and no frame is ready, further flags are sent one at a time. The framer checks at the end of each octet and starts a frame as soon as one is ready.
- R7: A frame is its data bytes, each sent LSB first, followed by the FCS. The FCS is CRC-16 with polynomial x^16+x^12+x^5+1, processed bit-reflected (0x8408), preset to 0xFFFF over the data bits. Its ones' complement is sent low byte first, each byte LSB first.
- R8: After five consecutive 1 bits inside data or FCS, a 0 bit is inserted. Flags are never stuffed, and their ones do not count toward a run.
- R9: `buf_irq` is a one-cycle pulse at the start of each frame, and there is exactly one pulse per frame sent.
- R10: Written bytes fill the two buffers alternately. A buffer closes on `wr_last` or when it holds DEPTH bytes. A write while the target buffer still holds an unsent frame is dropped.
- R11: A start command while a session is running, and a stop command while no session is running, have no effect.
- R12: `tx_vld` is high only in the cycle after a `bit_tick` that arrived during a session, and each such tick yields one line bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | Modulator request for the next line bit |
| start_cmd | input | 1 | Begin a session (one-cycle pulse) |
| stop_cmd | input | 1 | End the session after the queued frames (one-cycle pulse) |
| lead_flags | input | CNT_W | Extra flags before the first frame |
| gap_flags | input | CNT_W | Extra flags between frames |
| tail_flags | input | CNT_W | Extra flags after the last frame |
| wr_en | input | 1 | Write one frame byte |
| wr_data | input | 8 | Frame byte |
| wr_last | input | 1 | Byte written with it ends the frame |
| tx_bit | output | 1 | Line bit |
| tx_vld | output | 1 | `tx_bit` is valid this cycle |
| buf_irq | output | 1 | Frame drain started; the other buffer may be filled |

## Verification
The bench builds the framer with DEPTH=8 and CNT_W=15, and issues a bit request every third cycle. The small depth means an eight-byte frame without `wr_last` exercises the buffer's auto-close, and a third frame written into two full buffers exercises the write drop. The three-cycle bit period leaves room for the bench to write a frame in the middle of a flag octet. That makes the exact number of fill flags predictable, as well as the cycle at which a stop turns a fill run into the tail run.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

   localparam logic [7:0]  FLAG_OCTET = 8'h7E;
   localparam logic [15:0] FCS_POLY_R = 16'h8408;
   localparam logic [15:0] FCS_PRESET = 16'hFFFF;
   localparam int unsigned STUFF_RUN  = 5;

   typedef enum logic [1:0] {
      OCT_FLAG,
      OCT_DATA,
      OCT_FCS_LO,
      OCT_FCS_HI
   } octet_e;

   typedef enum logic [1:0] {
      PH_LEAD,
      PH_GAP,
      PH_TAIL
   } phase_e;

   // one bit of the reflected CRC-16 update
   function automatic logic [15:0] fcs_step(input logic [15:0] c, input logic b);
      logic [15:0] r;
      r = {1'b0, c[15:1]};
      if (c[0] ^ b) r = r ^ FCS_POLY_R;
      return r;
   endfunction

endpackage

// File: rtl/htx_pingpong.sv
module htx_pingpong
   #(parameter int DEPTH = 16,
     localparam int AW = $clog2(DEPTH),
     localparam int LW = AW + 1)
   (input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [7:0]    wr_data,
    input  logic          wr_last,
    input  logic          rd_sel,
    input  logic [AW-1:0] rd_addr,
    input  logic          release_i,
    output logic [1:0]    ready_o,
    output logic [7:0]    rd_data,
    output logic [LW-1:0] rd_len);

   localparam logic [AW-1:0] LAST_A = AW'(DEPTH - 1);
   localparam logic [LW-1:0] ONE_L  = LW'(1);

   logic          fsel_q;
   logic [AW-1:0] wcnt_q;
   logic          wr_ok;
   logic          wr_close;
   logic [7:0]    bank_rd  [2];
   logic [LW-1:0] bank_len [2];

   // a full target bank refuses the byte
   assign wr_ok    = wr_en && !ready_o[fsel_q];
   assign wr_close = wr_ok && (wr_last || (wcnt_q == LAST_A));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fsel_q <= 1'b0;
         wcnt_q <= '0;
      end else if (wr_ok) begin
         if (wr_close) begin
            fsel_q <= ~fsel_q;
            wcnt_q <= '0;
         end else begin
            wcnt_q <= wcnt_q + AW'(1);
         end
      end
   end

   for (genvar g = 0; g < 2; g++) begin : g_bank
      logic [7:0]    mem [DEPTH];
      logic          rdy_q;
      logic [LW-1:0] len_q;

      always_ff @(posedge clk) begin
         if (wr_ok && (fsel_q == 1'(g))) mem[wcnt_q] <= wr_data;
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            rdy_q <= 1'b0;
            len_q <= '0;
         end else if (wr_close && (fsel_q == 1'(g))) begin
            rdy_q <= 1'b1;
            len_q <= {1'b0, wcnt_q} + ONE_L;
         end else if (release_i && (rd_sel == 1'(g))) begin
            rdy_q <= 1'b0;
         end
      end

      assign ready_o[g]  = rdy_q;
      assign bank_rd[g]  = mem[rd_addr];
      assign bank_len[g] = len_q;
   end

   assign rd_data = bank_rd[rd_sel];
   assign rd_len  = bank_len[rd_sel];

endmodule

// File: rtl/htx_fcs.sv
module htx_fcs
   import hdlc_tx_pkg::*;
   (input  logic        clk,
    input  logic        rst_n,
    input  logic        init_i,
    input  logic        en_i,
    input  logic        bit_i,
    output logic [15:0] crc_q,
    output logic [15:0] crc_nx);

   assign crc_nx = en_i ? fcs_step(crc_q, bit_i) : crc_q;

   always_ff @(posedge clk) begin
      if (!rst_n)      crc_q <= FCS_PRESET;
      else if (init_i) crc_q <= FCS_PRESET;
      else             crc_q <= crc_nx;
   end

endmodule

// File: rtl/htx_seq.sv
module htx_seq
   import hdlc_tx_pkg::*;
   #(parameter int CNT_W = 15,
     parameter int AW    = 4,
     localparam int LW   = AW + 1)
   (input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_tick,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic [CNT_W-1:0] lead_n,
    input  logic [CNT_W-1:0] gap_n,
    input  logic [CNT_W-1:0] tail_n,
    input  logic [1:0]       buf_ready,
    input  logic [7:0]       rd_data,
    input  logic [LW-1:0]    rd_len,
    output logic             rd_sel,
    output logic [AW-1:0]    rd_addr,
    output logic             release_o,
    output logic             fcs_init,
    output logic             fcs_en,
    output logic             fcs_bit,
    input  logic [15:0]      crc_q,
    input  logic [15:0]      crc_nx,
    output logic             tx_bit,
    output logic             tx_vld,
    output logic             buf_irq,
    output logic             busy_o);

   localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);
   localparam logic [LW-1:0]    ONE_L = LW'(1);
   localparam logic [2:0]       RUN_L = 3'(STUFF_RUN);

   logic             busy_q;
   octet_e           kind_q;
   phase_e           phase_q;
   logic [CNT_W-1:0] left_q;
   logic [7:0]       sr_q;
   logic [2:0]       bidx_q;
   logic [2:0]       ones_q;
   logic [LW-1:0]    ptr_q;
   logic             dsel_q;
   logic             stop_q;

   logic stuff_now;
   logic real_bit;
   logic oct_end;
   logic run_done;
   logic frame_go;

   assign stuff_now = (ones_q == RUN_L);
   assign real_bit  = busy_q && bit_tick && !stuff_now;
   assign oct_end   = real_bit && (bidx_q == 3'd7);
   assign run_done  = (kind_q == OCT_FLAG) && (left_q == '0);
   assign frame_go  = oct_end && run_done && (phase_q != PH_TAIL) && buf_ready[dsel_q];

   assign rd_sel    = dsel_q;
   assign rd_addr   = ptr_q[AW-1:0];
   assign release_o = oct_end && (kind_q == OCT_DATA) && (ptr_q == rd_len);
   assign fcs_init  = frame_go;
   assign fcs_en    = real_bit && (kind_q == OCT_DATA);
   assign fcs_bit   = sr_q[0];
   assign busy_o    = busy_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         kind_q  <= OCT_FLAG;
         phase_q <= PH_LEAD;
         left_q  <= '0;
         sr_q    <= FLAG_OCTET;
         bidx_q  <= '0;
         ones_q  <= '0;
         ptr_q   <= '0;
         dsel_q  <= 1'b0;
         stop_q  <= 1'b0;
         tx_bit  <= 1'b0;
         tx_vld  <= 1'b0;
         buf_irq <= 1'b0;
      end else begin
         tx_vld  <= 1'b0;
         buf_irq <= 1'b0;
         if (!busy_q) begin
            if (start_i) begin
               busy_q  <= 1'b1;
               kind_q  <= OCT_FLAG;
               phase_q <= PH_LEAD;
               left_q  <= lead_n;
               sr_q    <= FLAG_OCTET;
               bidx_q  <= '0;
               ones_q  <= '0;
               stop_q  <= 1'b0;
            end
         end else begin
            if (stop_i) stop_q <= 1'b1;
            if (bit_tick) begin
               tx_vld <= 1'b1;
               if (stuff_now) begin
                  tx_bit <= 1'b0;
                  ones_q <= '0;
               end else begin
                  tx_bit <= sr_q[0];
                  sr_q   <= {1'b0, sr_q[7:1]};
                  bidx_q <= bidx_q + 3'd1;
                  if ((kind_q != OCT_FLAG) && sr_q[0]) ones_q <= ones_q + 3'd1;
                  else                                 ones_q <= '0;
                  if (bidx_q == 3'd7) begin
                     unique case (kind_q)
                        OCT_FLAG: begin
                           sr_q <= FLAG_OCTET;
                           if (left_q != '0) begin
                              left_q <= left_q - ONE_C;
                           end else if (phase_q == PH_TAIL) begin
                              busy_q <= 1'b0;
                              stop_q <= 1'b0;
                           end else if (frame_go) begin
                              kind_q  <= OCT_DATA;
                              sr_q    <= rd_data;
                              ptr_q   <= ONE_L;
                              buf_irq <= 1'b1;
                           end else if (stop_q) begin
                              phase_q <= PH_TAIL;
                              left_q  <= tail_n;
                           end
                        end
                        OCT_DATA: begin
                           if (release_o) begin
                              kind_q <= OCT_FCS_LO;
                              sr_q   <= ~crc_nx[7:0];
                              ptr_q  <= '0;
                              dsel_q <= ~dsel_q;
                           end else begin
                              sr_q  <= rd_data;
                              ptr_q <= ptr_q + ONE_L;
                           end
                        end
                        OCT_FCS_LO: begin
                           kind_q <= OCT_FCS_HI;
                           sr_q   <= ~crc_q[15:8];
                        end
                        OCT_FCS_HI: begin
                           kind_q <= OCT_FLAG;
                           sr_q   <= FLAG_OCTET;
                           if (stop_q && !buf_ready[dsel_q]) begin
                              phase_q <= PH_TAIL;
                              left_q  <= tail_n;
                           end else begin
                              phase_q <= PH_GAP;
                              left_q  <= gap_n;
                           end
                        end
                        default: kind_q <= OCT_FLAG;
                     endcase
                  end
               end
            end
         end
      end
   end

endmodule

// File: rtl/hdlc_flag_framer.sv
module hdlc_flag_framer
   import hdlc_tx_pkg::*;
   #(parameter int DEPTH = 16,
     parameter int CNT_W = 15)
   (input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_tick,
    input  logic             start_cmd,
    input  logic             stop_cmd,
    input  logic [CNT_W-1:0] lead_flags,
    input  logic [CNT_W-1:0] gap_flags,
    input  logic [CNT_W-1:0] tail_flags,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  logic             wr_last,
    output logic             tx_bit,
    output logic             tx_vld,
    output logic             buf_irq);

   localparam int AW = $clog2(DEPTH);
   localparam int LW = AW + 1;

   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt
      $error("CNT_W must lie in 1..16");
   end

   logic [1:0]    buf_ready;
   logic [7:0]    rd_data;
   logic [LW-1:0] rd_len;
   logic          rd_sel;
   logic [AW-1:0] rd_addr;
   logic          buf_release;
   logic          fcs_init;
   logic          fcs_en;
   logic          fcs_bit;
   logic [15:0]   crc_q;
   logic [15:0]   crc_nx;
   logic          seq_busy;

   htx_pingpong #(.DEPTH(DEPTH)) u_buf (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_data   (wr_data),
      .wr_last   (wr_last),
      .rd_sel    (rd_sel),
      .rd_addr   (rd_addr),
      .release_i (buf_release),
      .ready_o   (buf_ready),
      .rd_data   (rd_data),
      .rd_len    (rd_len));

   htx_fcs u_fcs (
      .clk    (clk),
      .rst_n  (rst_n),
      .init_i (fcs_init),
      .en_i   (fcs_en),
      .bit_i  (fcs_bit),
      .crc_q  (crc_q),
      .crc_nx (crc_nx));

   htx_seq #(.CNT_W(CNT_W), .AW(AW)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_tick  (bit_tick),
      .start_i   (start_cmd),
      .stop_i    (stop_cmd),
      .lead_n    (lead_flags),
      .gap_n     (gap_flags),
      .tail_n    (tail_flags),
      .buf_ready (buf_ready),
      .rd_data   (rd_data),
      .rd_len    (rd_len),
      .rd_sel    (rd_sel),
      .rd_addr   (rd_addr),
      .release_o (buf_release),
      .fcs_init  (fcs_init),
      .fcs_en    (fcs_en),
      .fcs_bit   (fcs_bit),
      .crc_q     (crc_q),
      .crc_nx    (crc_nx),
      .tx_bit    (tx_bit),
      .tx_vld    (tx_vld),
      .buf_irq   (buf_irq),
      .busy_o    (seq_busy));

endmodule

// File: rtl/htx_chk.sv
module htx_chk
   (input logic       clk,
    input logic       rst_n,
    input logic       bit_tick,
    input logic       tx_bit,
    input logic       tx_vld,
    input logic       buf_irq,
    input logic       busy,
    input logic [1:0] buf_ready);

   // length of the run of 1s seen on the line so far
   logic [3:0] run_q;

   always_ff @(posedge clk) begin
      if (!rst_n)      run_q <= '0;
      else if (tx_vld) run_q <= tx_bit ? ((run_q == 4'hF) ? run_q : run_q + 4'd1) : 4'd0;
   end

   // R12: each line bit answers a tick taken during a session
   p_vld_after_tick_r12: assert property (@(posedge clk) disable iff (!rst_n)
      tx_vld |-> $past(bit_tick && busy));

   // R8: only a flag reaches six ones in a row on the line
   p_max_ones_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_vld && tx_bit) |-> (run_q <= 4'd5));

   // R9: the buffer interrupt lasts one cycle
   p_irq_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      buf_irq |=> !buf_irq);

   // R9: the interrupt coincides with a line bit
   p_irq_on_bit_r9: assert property (@(posedge clk) disable iff (!rst_n)
      buf_irq |-> tx_vld);

   // R10: a full buffer is emptied only by the drain side
   p_bank0_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(buf_ready[0]) |-> $past(busy));

   p_bank1_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(buf_ready[1]) |-> $past(busy));

endmodule

bind hdlc_flag_framer htx_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bit_tick  (bit_tick),
   .tx_bit    (tx_bit),
   .tx_vld    (tx_vld),
   .buf_irq   (buf_irq),
   .busy      (seq_busy),
   .buf_ready (buf_ready));

// File: tb/sim_hdlc_flag_framer.sv
`timescale 1ns/1ps
module sim_hdlc_flag_framer;

   localparam int DEPTH = 8;
   localparam int CNT_W = 15;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             bit_tick = 1'b0;
   logic             start_cmd = 1'b0;
   logic             stop_cmd = 1'b0;
   logic [CNT_W-1:0] lead_flags = '0;
   logic [CNT_W-1:0] gap_flags = '0;
   logic [CNT_W-1:0] tail_flags = '0;
   logic             wr_en = 1'b0;
   logic [7:0]       wr_data = '0;
   logic             wr_last = 1'b0;
   logic             tx_bit;
   logic             tx_vld;
   logic             buf_irq;

   always #2 clk = ~clk;

   hdlc_flag_framer #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u0 (.*);

   typedef struct { logic b; int req; } exp_t;
   exp_t q[$];

   int checks = 0;
   int errors = 0;
   int nbits  = 0;
   int nirq   = 0;
   int m_ones = 0;
   bit done   = 0;
   logic tick_seen = 1'b0;

   // bit request every third cycle
   initial begin
      int c = 0;
      forever begin
         @(posedge clk); #1;
         bit_tick = (c == 2);
         c = (c == 2) ? 0 : c + 1;
      end
   end

   // monitor: pops expected line bits
   initial begin
      forever begin
         @(negedge clk);
         if (buf_irq) nirq++;
         if (tx_vld) begin
            nbits++;
            checks++;
            if (!tick_seen) begin
               errors++;
               $display("FAIL R12 bit without tick: actual tx_vld=1 expected 0");
            end
            if (q.size() == 0) begin
               errors++;
               $display("FAIL R4 line not quiet: actual bit %0b expected none", tx_bit);
            end else begin
               exp_t e;
               e = q.pop_front();
               if (tx_bit !== e.b) begin
                  errors++;
                  $display("FAIL R%0d line bit %0d: actual %0b expected %0b", e.req, nbits, tx_bit, e.b);
               end
            end
         end
         tick_seen = bit_tick;
      end
   end

   task automatic push_bit(input logic b, input int r);
      exp_t e;
      e.b = b; e.req = r;
      q.push_back(e);
   endtask

   task automatic push_flags(input int n, input int r);
      for (int k = 0; k < n; k++)
         for (int i = 0; i < 8; i++) push_bit(i != 0 && i != 7, r);
      m_ones = 0;
   endtask

   // content bit with zero insertion (R8)
   task automatic push_body(input logic b, input int r);
      push_bit(b, r);
      m_ones = b ? m_ones + 1 : 0;
      if (m_ones == 5) begin
         push_bit(1'b0, 8);
         m_ones = 0;
      end
   endtask

   task automatic push_frame(input logic [7:0] d[16], input int n);
      logic [15:0] c;
      logic [15:0] f;
      logic        fb;
      c = 16'hFFFF;
      m_ones = 0;
      for (int k = 0; k < n; k++)
         for (int i = 0; i < 8; i++) begin
            push_body(d[k][i], 7);
            fb = c[0] ^ d[k][i];
            c  = c >> 1;
            if (fb) c = c ^ 16'h8408;
         end
      f = ~c;
      for (int i = 0; i < 16; i++) push_body(f[i], 7);
   endtask

   task automatic write_frame(input logic [7:0] d[16], input int n, input bit mark_last);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         wr_en   = 1'b1;
         wr_data = d[k];
         wr_last = mark_last && (k == n - 1);
      end
      @(negedge clk);
      wr_en   = 1'b0;
      wr_last = 1'b0;
   endtask

   task automatic pulse_start();
      @(negedge clk); start_cmd = 1'b1;
      @(negedge clk); start_cmd = 1'b0;
   endtask

   task automatic pulse_stop();
      @(negedge clk); stop_cmd = 1'b1;
      @(negedge clk); stop_cmd = 1'b0;
   endtask

   task automatic wait_bits(input int n);
      while (nbits < n) @(posedge clk);
   endtask

   task automatic begin_scn();
      @(negedge clk);
      nbits = 0;
      nirq  = 0;
   endtask

   task automatic end_scn(input int exp_irq, input string tag);
      int guard = 0;
      while (q.size() != 0 && guard < 30000) begin
         @(posedge clk);
         guard++;
      end
      repeat (60) @(posedge clk);
      checks++;
      if (q.size() != 0) begin
         errors++;
         $display("FAIL %s stream short: actual %0d bits left expected 0", tag, q.size());
         q.delete();
      end
      checks++;
      if (nirq != exp_irq) begin
         errors++;
         $display("FAIL R9 %s irq count: actual %0d expected %0d", tag, nirq, exp_irq);
      end
   endtask

   logic [7:0] fa[16], fb_[16], fs[16], ff[16], fc[16], fd[16], fe[16];

   initial begin
      for (int k = 0; k < 16; k++) begin
         fa[k] = '0; fb_[k] = '0; fs[k] = '0; ff[k] = '0;
         fc[k] = 8'(k * 29 + 7); fd[k] = '0; fe[k] = '0;
      end
      fa[0] = 8'h01; fa[1] = 8'hA5; fa[2] = 8'h3C;
      fb_[0] = 8'hFF; fb_[1] = 8'h80;
      fs[0] = 8'hFF; fs[1] = 8'h7E; fs[2] = 8'hF8; fs[3] = 8'h1F;
      ff[0] = 8'h55;
      fd[0] = 8'h0F; fd[1] = 8'hF0;
      fe[0] = 8'hAA;

      repeat (5) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;

      // R1: quiet after reset, ticks running
      for (int i = 0; i < 16; i++) begin
         @(negedge clk);
         checks++;
         if (tx_vld !== 1'b0 || buf_irq !== 1'b0) begin
            errors++;
            $display("FAIL R1 idle outputs: actual vld=%0b irq=%0b expected 0 0", tx_vld, buf_irq);
         end
      end

      // R2 R3 R4 R11: two queued frames, early stop, second start ignored
      begin_scn();
      lead_flags = 15'd2; gap_flags = 15'd1; tail_flags = 15'd3;
      push_flags(3, 2);
      push_frame(fa, 3);
      push_flags(2, 3);
      push_frame(fb_, 2);
      push_flags(4, 4);
      write_frame(fa, 3, 1);
      write_frame(fb_, 2, 1);
      pulse_start();
      pulse_stop();
      wait_bits(40);
      pulse_start(); // R11: ignored mid-session
      end_scn(2, "R4 queued");

      // R7 R8: stuffing-heavy frame, tail replaces the gap run
      begin_scn();
      lead_flags = 15'd0; gap_flags = 15'd5; tail_flags = 15'd0;
      push_flags(1, 2);
      push_frame(fs, 4);
      push_flags(1, 4);
      write_frame(fs, 4, 1);
      pulse_start();
      pulse_stop();
      end_scn(1, "R8 stuffing");

      // R6 R11: stop before start ignored, host late, fill flags
      begin_scn();
      lead_flags = 15'd0; gap_flags = 15'd0; tail_flags = 15'd0;
      pulse_stop(); // R11: no session yet
      push_flags(6, 6);
      push_frame(ff, 1);
      push_flags(1, 4);
      pulse_start();
      wait_bits(40);
      write_frame(ff, 1, 1);
      pulse_stop();
      end_scn(1, "R6 fill");

      // R5: stop while only flags are being sent
      begin_scn();
      lead_flags = 15'd1; gap_flags = 15'd0; tail_flags = 15'd2;
      push_flags(2, 2);
      push_flags(2, 6);
      push_flags(3, 5);
      pulse_start();
      wait_bits(24);
      pulse_stop();
      end_scn(0, "R5 flag-only stop");

      // R10: auto-close at DEPTH bytes, write into two full buffers dropped
      begin_scn();
      lead_flags = 15'd0; gap_flags = 15'd0; tail_flags = 15'd0;
      push_flags(1, 2);
      push_frame(fc, DEPTH);
      push_flags(1, 3);
      push_frame(fd, 2);
      push_flags(1, 4);
      write_frame(fc, DEPTH, 0);
      write_frame(fd, 2, 1);
      write_frame(fe, 1, 1);
      pulse_start();
      pulse_stop();
      end_scn(2, "R10 buffers");

      // R10: buffers usable again after the dropped write
      begin_scn();
      push_flags(1, 2);
      push_frame(fe, 1);
      push_flags(1, 4);
      write_frame(fe, 1, 1);
      pulse_start();
      pulse_stop();
      end_scn(1, "R10 reuse");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(150000 * 4);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R12 watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule